// File: doc/BRIEF.md
# Bridge Module Reset Controller

This block gives software direct control over the reset lines of seven interconnect modules: three processor-to-fabric and fabric-to-processor bridges, three SDRAM port bridges and the DDR scheduler. Software writes a 32-bit control word over a simple register bus. A bit at 1 holds its module in reset, and a bit at 0 releases it. Every reset line starts out asserted, so nothing behind the bridges runs until software releases it on purpose. Pulse length and release order are up to software.

A second register, the warm mask, decides which control bits a warm reset request sets back to 1. A cold reset sets both registers to all ones, whatever else is happening. Each reset output goes high as soon as its control bit is set. It goes low only after its control bit clears and two rising edges of the module's own clock have passed.

Top module: `bridge_rst_ctl`

## Requirements
- R1: The control register is at byte address 0x2C and the warm-mask register is at 0x30. Both use bits 6:0 in this order: bit 0 processor-to-fabric bridge, bit 1 lightweight processor-to-fabric bridge, bit 2 fabric-to-processor bridge, bits 3/4/5 SDRAM bridges 0/1/2, bit 6 DDR scheduler. Output mod_rst[i] belongs to bit i.
- R2: After a cold reset, both registers read 0x0000007F and all seven mod_rst outputs are high.
- R3: A write with wr_en high to address 0x2C stores wr_data[6:0]. A read of 0x2C in the next cycle returns that value.
- R4: Bits 31:7 of both registers always read 0, and writing ones to them changes nothing. A write to any other address has no effect. A read of any other address returns 0. rd_data is 0 whenever rd_en is low.
- R5: While cold_rst_n is low, both registers are all ones and all mod_rst outputs are high, without waiting for a clock edge. This overrides every other input.
- R6: On a cycle with warm_req high, each control bit whose mask bit is 1 becomes 1. Each control bit whose mask bit is 0 keeps its value.
- R7: The warm-mask register is changed only by a cold reset or by a write to 0x30. A warm request leaves it unchanged.
- R8: When warm_req is high in the same cycle as a bus write, the write to either register is dropped.
- R9: mod_rst[i] goes high in the same cycle its control bit becomes 1, with no edge needed on dst_clk[i].
- R10: After control bit i goes to 0, mod_rst[i] stays high through the first rising edge of dst_clk[i]. It falls at the second rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register bus clock |
| cold_rst_n | input | 1 | Asynchronous cold reset, active low |
| warm_req | input | 1 | Warm reset request, one cycle, synchronous to clk |
| addr | input | 8 | Byte address of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Read data, combinational from addr and rd_en |
| dst_clk | input | 7 | Clock of each module being reset |
| mod_rst | output | 7 | Active-high reset to each module |

## Verification
The bound checker checks these on every clk edge:
- reserved bits read back as zero;
- writes are stored and held;
- warm reloads follow the mask;
- the mask is unaffected by warm requests;
- warm requests win over writes;
- the reset outputs are never lower than the control bits.

The bench covers what needs the other clock domains or a full sweep. It covers the two-edge release on each destination clock, asynchronous assertion under a cold reset, all 128 control patterns seen at the outputs, and all 128 mask patterns under warm requests.

// File: rtl/brc_pkg.sv
package brc_pkg;
  localparam int NUM_MOD     = 7;
  localparam int ADDR_W      = 8;
  localparam int DATA_W      = 32;
  localparam int SYNC_STAGES = 2;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 8'h2C;
  localparam logic [ADDR_W-1:0] MASK_OFS = 8'h30;

  // Warm reload: masked fields go to 1, unmasked keep their value.
  function automatic logic [NUM_MOD-1:0] warm_reload(
    input logic [NUM_MOD-1:0] cur,
    input logic [NUM_MOD-1:0] msk
  );
    return cur | msk;
  endfunction

  // Zero-extend a field vector onto the bus.
  function automatic logic [DATA_W-1:0] to_bus(input logic [NUM_MOD-1:0] f);
    logic [DATA_W-1:0] w;
    w = '0;
    w[NUM_MOD-1:0] = f;
    return w;
  endfunction
endpackage

// File: rtl/brc_decode.sv
module brc_decode
  import brc_pkg::*;
#(
  parameter int NMOD  = NUM_MOD,
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter logic [AW-1:0] C_OFS = CTRL_OFS,
  parameter logic [AW-1:0] M_OFS = MASK_OFS
) (
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic [NMOD-1:0] ctrl_q,
  input  logic [NMOD-1:0] mask_q,
  output logic            ctrl_wr_hit,
  output logic            mask_wr_hit,
  output logic [DW-1:0]   rd_data
);
  logic ctrl_sel, mask_sel;

  assign ctrl_sel    = (addr == C_OFS);
  assign mask_sel    = (addr == M_OFS);
  assign ctrl_wr_hit = wr_en && ctrl_sel;
  assign mask_wr_hit = wr_en && mask_sel;

  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      if (ctrl_sel)      rd_data[NMOD-1:0] = ctrl_q;
      else if (mask_sel) rd_data[NMOD-1:0] = mask_q;
    end
  end
endmodule

// File: rtl/brc_regfile.sv
module brc_regfile
  import brc_pkg::*;
#(
  parameter int NMOD = NUM_MOD
) (
  input  logic            clk,
  input  logic            cold_rst_n,
  input  logic            warm_req,
  input  logic            ctrl_wr_hit,
  input  logic            mask_wr_hit,
  input  logic [NMOD-1:0] wr_field,
  output logic [NMOD-1:0] ctrl_q,
  output logic [NMOD-1:0] mask_q
);
  // Priority: cold (async) > warm > bus write.
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      ctrl_q <= '1;
      mask_q <= '1;
    end else if (warm_req) begin
      ctrl_q <= warm_reload(ctrl_q, mask_q);
    end else begin
      if (ctrl_wr_hit) ctrl_q <= wr_field;
      if (mask_wr_hit) mask_q <= wr_field;
    end
  end
endmodule

// File: rtl/brc_rst_sync.sv
module brc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic dst_clk,
  input  logic rst_req,
  output logic rst_out
);
  logic [STAGES-1:0] chain;

  // Asynchronous set, release shifted through STAGES flops.
  always_ff @(posedge dst_clk or posedge rst_req) begin
    if (rst_req) chain <= '1;
    else         chain <= {chain[STAGES-2:0], 1'b0};
  end

  assign rst_out = chain[STAGES-1];
endmodule

// File: rtl/bridge_rst_ctl.sv
module bridge_rst_ctl
  import brc_pkg::*;
#(
  parameter int NMOD   = NUM_MOD,
  parameter int AW     = ADDR_W,
  parameter int DW     = DATA_W,
  parameter int STAGES = SYNC_STAGES
) (
  input  logic            clk,
  input  logic            cold_rst_n,
  input  logic            warm_req,
  input  logic [AW-1:0]   addr,
  input  logic            wr_en,
  input  logic [DW-1:0]   wr_data,
  input  logic            rd_en,
  output logic [DW-1:0]   rd_data,
  input  logic [NMOD-1:0] dst_clk,
  output logic [NMOD-1:0] mod_rst
);
  logic [NMOD-1:0]    ctrl_q, mask_q, wr_field;
  logic               ctrl_wr_hit, mask_wr_hit;
  logic [DW-NMOD-1:0] wr_rsvd;
  logic               wr_rsvd_nz;

  // Split the write word into fields and the reserved bits, which are dropped.
  assign wr_field   = wr_data[NMOD-1:0];
  assign wr_rsvd    = wr_data[DW-1:NMOD];
  assign wr_rsvd_nz = |wr_rsvd;

  brc_decode #(.NMOD(NMOD), .AW(AW), .DW(DW)) u_dec (
    .addr        (addr),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .ctrl_q      (ctrl_q),
    .mask_q      (mask_q),
    .ctrl_wr_hit (ctrl_wr_hit),
    .mask_wr_hit (mask_wr_hit),
    .rd_data     (rd_data)
  );

  brc_regfile #(.NMOD(NMOD)) u_regs (
    .clk         (clk),
    .cold_rst_n  (cold_rst_n),
    .warm_req    (warm_req),
    .ctrl_wr_hit (ctrl_wr_hit),
    .mask_wr_hit (mask_wr_hit),
    .wr_field    (wr_field),
    .ctrl_q      (ctrl_q),
    .mask_q      (mask_q)
  );

  for (genvar i = 0; i < NMOD; i++) begin : g_sync
    brc_rst_sync #(.STAGES(STAGES)) u_sync (
      .dst_clk (dst_clk[i]),
      .rst_req (ctrl_q[i]),
      .rst_out (mod_rst[i])
    );
  end
endmodule

// File: rtl/brc_checker.sv
module brc_checker #(
  parameter int NMOD = 7,
  parameter int DW   = 32
) (
  input logic            clk,
  input logic            cold_rst_n,
  input logic            warm_req,
  input logic [DW-1:0]   wr_data,
  input logic [DW-1:0]   rd_data,
  input logic [NMOD-1:0] ctrl_q,
  input logic [NMOD-1:0] mask_q,
  input logic            ctrl_wr_hit,
  input logic            mask_wr_hit,
  input logic            wr_rsvd_nz,
  input logic [NMOD-1:0] mod_rst
);
  logic after_cold;
  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) after_cold <= 1'b1;
    else             after_cold <= 1'b0;
  end

  // R2 / R5: first edge after a cold reset sees all ones in both registers
  a_r5_cold_ones: assert property (@(posedge clk) disable iff (!cold_rst_n)
    after_cold |-> (ctrl_q == '1 && mask_q == '1));

  // R4: reserved read bits are zero
  a_r4_rsvd_zero: assert property (@(posedge clk) disable iff (!cold_rst_n)
    rd_data[DW-1:NMOD] == '0);

  // R4: reserved write bits do not reach the control field
  a_r4_rsvd_wr_drop: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (ctrl_wr_hit && !warm_req && wr_rsvd_nz) |=> ctrl_q == $past(wr_data[NMOD-1:0]));

  // R3: a write stores the field
  a_r3_write_store: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (ctrl_wr_hit && !warm_req) |=> ctrl_q == $past(wr_data[NMOD-1:0]));

  // R3: without write or warm the control value holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (!ctrl_wr_hit && !warm_req) |=> $stable(ctrl_q));

  // R6: masked fields become 1, unmasked fields keep their value
  a_r6_warm_set: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |=> ((ctrl_q & $past(mask_q)) == $past(mask_q)));
  a_r6_warm_keep: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |=> ((ctrl_q & ~$past(mask_q)) == ($past(ctrl_q) & ~$past(mask_q))));

  // R7 / R8: warm leaves the mask untouched even with a mask write
  a_r7_mask_warm: assert property (@(posedge clk) disable iff (!cold_rst_n)
    warm_req |=> $stable(mask_q));

  // R7: mask changes only through its own write
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!cold_rst_n)
    !mask_wr_hit |=> $stable(mask_q));

  // R9: a set control bit always has its reset output high
  a_r9_out_cover: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (mod_rst & ctrl_q) == ctrl_q);
endmodule

bind bridge_rst_ctl brc_checker #(.NMOD(NMOD), .DW(DW)) u_chk (
  .clk         (clk),
  .cold_rst_n  (cold_rst_n),
  .warm_req    (warm_req),
  .wr_data     (wr_data),
  .rd_data     (rd_data),
  .ctrl_q      (ctrl_q),
  .mask_q      (mask_q),
  .ctrl_wr_hit (ctrl_wr_hit),
  .mask_wr_hit (mask_wr_hit),
  .wr_rsvd_nz  (wr_rsvd_nz),
  .mod_rst     (mod_rst)
);

// File: tb/bridge_rst_ctl_bench.sv
`timescale 1ns/1ps
module bridge_rst_ctl_bench;
  localparam logic [7:0] A_CTRL = 8'h2C;
  localparam logic [7:0] A_MASK = 8'h30;

  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0;
  logic        warm_req = 1'b0;
  logic [7:0]  addr = '0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [31:0] rd_data;
  logic [6:0]  dst_clk, fclk;
  logic [6:0]  man_clk = '0;
  logic        man_mode = 1'b0;
  logic [6:0]  mod_rst;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  for (genvar i = 0; i < 7; i++) begin : g_fclk
    logic fc = 1'b0;
    always #(3.1 + 1.3 * i) fc = ~fc;
    assign fclk[i] = fc;
  end
  assign dst_clk = man_mode ? man_clk : fclk;

  bridge_rst_ctl u_bridge_rst_ctl (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_req(warm_req), .addr(addr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .dst_clk(dst_clk), .mod_rst(mod_rst)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, input logic warm);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; warm_req = warm;
    @(negedge clk);
    wr_en = 1'b0; warm_req = 1'b0; wr_data = '0;
  endtask

  task automatic warm_pulse();
    @(negedge clk);
    warm_req = 1'b1;
    @(negedge clk);
    warm_req = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic man_edge(input int i);
    #1 man_clk[i] = 1'b1;
    #1 man_clk[i] = 1'b0;
    #1;
  endtask

  initial begin
    #200000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #1 check("R5 outputs high during cold reset", {25'd0, mod_rst}, 32'h7F);
    cold_rst_n = 1'b1;

    // R2 reset state
    bus_rd(A_CTRL, v); check("R2 ctrl reset value", v, 32'h7F);
    bus_rd(A_MASK, v); check("R2 mask reset value", v, 32'h7F);
    check("R2 outputs after reset", {25'd0, mod_rst}, 32'h7F);

    // R3 / R4 / R1: all 128 control patterns, reserved bits written as ones
    for (int p = 0; p < 128; p++) begin
      bus_wr(A_CTRL, {25'h1FFFFFF, p[6:0]}, 1'b0);
      bus_rd(A_CTRL, v);
      check("R3 R4 ctrl readback", v, {25'd0, p[6:0]});
      repeat (12) @(negedge clk);
      check("R1 R10 outputs follow ctrl", {25'd0, mod_rst}, {25'd0, p[6:0]});
    end

    // R9: asynchronous assertion with destination clocks stopped
    bus_wr(A_CTRL, 32'h7F, 1'b0);
    @(negedge clk); man_mode = 1'b1;
    bus_wr(A_CTRL, 32'h00, 1'b0);
    man_edge(0); man_edge(1); man_edge(2); man_edge(3);
    man_edge(4); man_edge(5); man_edge(6);
    man_edge(0); man_edge(1); man_edge(2); man_edge(3);
    man_edge(4); man_edge(5); man_edge(6);
    check("R10 all released by manual edges", {25'd0, mod_rst}, 32'h0);
    for (int i = 0; i < 7; i++) begin
      bus_wr(A_CTRL, 32'h1 << i, 1'b0);
      check("R9 immediate assertion", {25'd0, mod_rst}, 32'h1 << i);
      bus_wr(A_CTRL, 32'h0, 1'b0);
      check("R10 held before dst edge", {25'd0, mod_rst}, 32'h1 << i);
      man_edge(i);
      check("R10 held after first edge", {25'd0, mod_rst}, 32'h1 << i);
      man_edge(i);
      check("R10 released after second edge", {25'd0, mod_rst}, 32'h0);
    end
    bus_wr(A_CTRL, 32'h7F, 1'b0);
    @(negedge clk); man_mode = 1'b0;

    // R6 / R7: all 128 mask patterns
    for (int m = 0; m < 128; m++) begin
      logic [6:0] c;
      c = 7'((m * 29 + 11) & 8'h7F);
      bus_wr(A_MASK, {25'h1FFFFFF, m[6:0]}, 1'b0);
      bus_wr(A_CTRL, {25'd0, c}, 1'b0);
      warm_pulse();
      bus_rd(A_CTRL, v);
      check("R6 warm reload by mask", v, {25'd0, c | m[6:0]});
      bus_rd(A_MASK, v);
      check("R7 mask kept across warm", v, {25'd0, m[6:0]});
    end

    // R8: warm wins over writes in the same cycle
    bus_wr(A_MASK, 32'h0F, 1'b0);
    bus_wr(A_CTRL, 32'h00, 1'b0);
    bus_wr(A_CTRL, 32'h70, 1'b1);
    bus_rd(A_CTRL, v); check("R8 ctrl write dropped under warm", v, 32'h0F);
    bus_wr(A_MASK, 32'h7F, 1'b1);
    bus_rd(A_MASK, v); check("R8 mask write dropped under warm", v, 32'h0F);

    // R4: other addresses and read strobe
    bus_wr(A_CTRL, 32'h2A, 1'b0);
    bus_wr(8'h28, 32'hFFFFFFFF, 1'b0);
    bus_wr(8'h34, 32'h0, 1'b0);
    bus_wr(8'hFF, 32'h0, 1'b0);
    bus_rd(A_CTRL, v); check("R4 unmapped writes ignored", v, 32'h2A);
    bus_rd(A_MASK, v); check("R4 mask untouched by unmapped", v, 32'h0F);
    bus_rd(8'h28, v);  check("R4 unmapped read zero", v, 32'h0);
    @(negedge clk); addr = A_CTRL; rd_en = 1'b0;
    #1 check("R4 no read strobe gives zero", rd_data, 32'h0);

    // R5: cold reset mid operation
    bus_wr(A_CTRL, 32'h00, 1'b0);
    bus_wr(A_MASK, 32'h00, 1'b0);
    repeat (12) @(negedge clk);
    check("R5 released before cold", {25'd0, mod_rst}, 32'h0);
    #1 cold_rst_n = 1'b0;
    #0.5 check("R5 outputs assert asynchronously", {25'd0, mod_rst}, 32'h7F);
    @(negedge clk); cold_rst_n = 1'b1;
    bus_rd(A_CTRL, v); check("R5 ctrl ones after cold", v, 32'h7F);
    bus_rd(A_MASK, v); check("R5 mask ones after cold", v, 32'h7F);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule